// File: doc/BRIEF.md
# CCD Vertical Region Sequencer

This block produces the vertical transfer clocks for a CCD sensor that is read out over several fields in turn. A pixel counter restarts on every horizontal sync and a line counter restarts on every vertical sync. Within the active field, a set of programmable line boundaries splits the frame into four regions. For each region, a per-field selector chooses what to play: nothing, a fast sweep that clears charge from the vertical registers, an ordinary single-line shift, or the sensor-gate transfer line. The gate line uses a second pattern group.

The block drives six vertical clocks, a sensor-gate strobe, a horizontal blanking enable and a clamp enable. Each output has a polarity bit, because the external vertical driver usually inverts these signals. Software writes through a small address/data port into shadow copies. The copies take effect only on the next vertical sync, so a field never changes while it is being read.

Top module: `ccd_vseq`

## Requirements
- R1: After reset all nine outputs are low and the field index is the last field (NFIELDS-1), so the first vertical sync selects field 0.
- R2: A write with `wr_en` high lands in a shadow copy and changes no output until the next `vsync`, when every shadow value becomes active at once. Address map (data is {off[15:8], on[7:0]} for windows): field f at f*8+r is the start line of region r (r=1..3) and at f*8+4+r is the sequence code of region r (r=0..3); 32+k is the group-A window of vertical clock k; 40+k is the group-B window of clock k; 48 is the gate window; 49 is the blanking window; 50 is the clamp window; 51 is the sweep setup {count[15:8], period[7:0]}; 52 is the polarity.
- R3: On `vsync` the pixel count, line count and region index return to 0, and the field index steps by one, wrapping from NFIELDS-1 to 0.
- R4: On `hsync` the pixel count restarts and the line count increments. The region index steps by one when the new line count equals the start line of the next region. Once the last region (3) is reached, the index holds there until `vsync`.
- R5: Each field has its own boundaries and codes. The sequence codes are 0 idle, 1 sweep, 2 single-line shift and 3 gate line. The code of the current field and region selects the output behaviour.
- R6: In shift mode, vertical clock k is active while on_A[k] <= pixel < off_A[k]. Every output is registered, so its value after clock edge n reflects the pixel count held just before edge n.
- R7: In gate mode, vertical clock k follows the group-B window instead, and the sensor-gate output is active inside the gate window. In every other mode the gate output is inactive.
- R8: In sweep mode all six vertical clocks pulse together. A pulse lasts period cycles, with the first period/2 cycles active. After count pulses the clocks stay inactive until the region or field changes. The blanking output is held active for the whole sweep region, and a region boundary ends the sweep.
- R9: Outside sweep mode, blanking is active while hblk_on <= pixel < hblk_off, and clamp is active while clamp_on <= pixel < clamp_off (clamp applies in sweep mode as well).
- R10: In idle mode the vertical clocks and the gate output are inactive.
- R11: Each output is the raw level XOR its polarity bit. The polarity bits are [5:0] vertical clocks, 6 gate, 7 blanking, 8 clamp.
- R12: Two regions that carry the same code produce identical output from the same stored pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | One-cycle line start strobe |
| vsync | input | 1 | One-cycle field start strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 16 | Register write data |
| v_out | output | 6 | Vertical transfer clocks |
| sg_out | output | 1 | Sensor-gate strobe |
| hblk_out | output | 1 | Horizontal blanking enable |
| clamp_out | output | 1 | Clamp enable |

## Verification
The assertions check the following on every cycle:
- the reset state of the outputs;
- that the active configuration is frozen between vertical syncs;
- the field wrap;
- that the region index either holds or steps by one and sticks at the last region;
- that the gate strobe stays inactive outside gate mode;
- that blanking is forced during sweep;
- that idle mode keeps the vertical clocks quiet.

Only the directed scenarios can show the exact pixel positions of each window. The same applies to the one-cycle output latency, the sweep pulse train and its stop after the programmed count, the mapping of regions to lines, and the effect of polarity on each output.

// File: rtl/ccd_vseq_pkg.sv
package ccd_vseq_pkg;
    parameter int PIX_W  = 8;
    parameter int LINE_W = 10;
    parameter int NV     = 6;
    parameter int NR     = 4;
    parameter int ADDR_W = 6;
    localparam int DATA_W = 2 * PIX_W;
    localparam int POL_W  = NV + 3;
    localparam int REG_W  = $clog2(NR);

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SWEEP = 2'd1,
        SEQ_SHIFT = 2'd2,
        SEQ_GATE  = 2'd3
    } seq_e;

    // pixel window: active for on <= pix < off
    typedef struct packed {
        logic [PIX_W-1:0] off;
        logic [PIX_W-1:0] on;
    } win_t;

    typedef struct packed {
        logic [POL_W-1:0]  pol;
        logic [PIX_W-1:0]  sw_count;
        logic [PIX_W-1:0]  sw_period;
        win_t              clamp;
        win_t              hblk;
        win_t              gate;
        win_t [NV-1:0]     grp_b;
        win_t [NV-1:0]     grp_a;
    } glob_t;

    typedef struct packed {
        seq_e [NR-1:0]             sel;
        logic [NR-1:1][LINE_W-1:0] bnd;
    } fld_t;

    function automatic logic in_win(input logic [PIX_W-1:0] p, input win_t w);
        return (p >= w.on) && (p < w.off);
    endfunction
endpackage

// File: rtl/ccd_vseq_regs.sv
module ccd_vseq_regs
    import ccd_vseq_pkg::*;
#(
    parameter int  NFIELDS = 3,
    localparam int FLD_W   = (NFIELDS > 1) ? $clog2(NFIELDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vsync,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FLD_W-1:0]  field,
    output fld_t              cur_fld,
    output glob_t             act_glob
);
    fld_t  shd_fld [NFIELDS];
    fld_t  act_fld [NFIELDS];
    glob_t shd_glob;

    logic       glob_blk;
    logic [2:0] sub;
    logic [4:0] goff;

    assign glob_blk = wr_addr[5];
    assign sub      = wr_addr[2:0];
    assign goff     = wr_addr[4:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int f = 0; f < NFIELDS; f++) begin
                shd_fld[f] <= '0;
                act_fld[f] <= '0;
            end
            shd_glob <= '0;
            act_glob <= '0;
        end else begin
            if (wr_en && !glob_blk) begin
                for (int f = 0; f < NFIELDS; f++) begin
                    if (wr_addr[4:3] == 2'(f)) begin
                        for (int r = 1; r < NR; r++)
                            if (sub == 3'(r)) shd_fld[f].bnd[r] <= wr_data[LINE_W-1:0];
                        for (int r = 0; r < NR; r++)
                            if (sub == 3'(4 + r)) shd_fld[f].sel[r] <= seq_e'(wr_data[1:0]);
                    end
                end
            end
            if (wr_en && glob_blk) begin
                for (int k = 0; k < NV; k++) begin
                    if (goff == 5'(k))     shd_glob.grp_a[k] <= win_t'(wr_data);
                    if (goff == 5'(8 + k)) shd_glob.grp_b[k] <= win_t'(wr_data);
                end
                if (goff == 5'd16) shd_glob.gate  <= win_t'(wr_data);
                if (goff == 5'd17) shd_glob.hblk  <= win_t'(wr_data);
                if (goff == 5'd18) shd_glob.clamp <= win_t'(wr_data);
                if (goff == 5'd19) begin
                    shd_glob.sw_period <= wr_data[PIX_W-1:0];
                    shd_glob.sw_count  <= wr_data[DATA_W-1:PIX_W];
                end
                if (goff == 5'd20) shd_glob.pol <= wr_data[POL_W-1:0];
            end
            if (vsync) begin
                act_fld  <= shd_fld;
                act_glob <= shd_glob;
            end
        end
    end

    assign cur_fld = act_fld[field];
endmodule

// File: rtl/ccd_vseq_timebase.sv
module ccd_vseq_timebase
    import ccd_vseq_pkg::*;
#(
    parameter int  NFIELDS = 3,
    localparam int FLD_W   = (NFIELDS > 1) ? $clog2(NFIELDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync,
    input  logic             vsync,
    input  fld_t             cur_fld,
    input  logic [PIX_W-1:0] sw_period,
    input  logic [PIX_W-1:0] sw_count,
    output logic [PIX_W-1:0] pix,
    output logic [FLD_W-1:0] field,
    output logic [REG_W-1:0] region,
    output seq_e             mode,
    output logic             sweep_hi
);
    logic [LINE_W-1:0] line_q, line_nxt;
    logic [PIX_W-1:0]  sw_tmr, sw_cnt;
    logic              adv, sweeping;

    assign line_nxt = (line_q == '1) ? line_q : line_q + 1'b1;
    assign mode     = cur_fld.sel[region];
    assign sweeping = (mode == SEQ_SWEEP) && (sw_cnt < sw_count);
    assign sweep_hi = sweeping && (sw_tmr < (sw_period >> 1));

    always_comb begin
        adv = 1'b0;
        for (int r = 1; r < NR; r++)
            if (region == REG_W'(r - 1) && cur_fld.bnd[r] == line_nxt) adv = hsync;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix    <= '0;
            line_q <= '0;
            region <= '0;
            field  <= FLD_W'(NFIELDS - 1);
            sw_tmr <= '0;
            sw_cnt <= '0;
        end else if (vsync) begin
            pix    <= '0;
            line_q <= '0;
            region <= '0;
            field  <= (field == FLD_W'(NFIELDS - 1)) ? '0 : field + 1'b1;
            sw_tmr <= '0;
            sw_cnt <= '0;
        end else begin
            if (hsync) begin
                pix    <= '0;
                line_q <= line_nxt;
                if (adv) region <= region + 1'b1;
            end else if (pix != '1) begin
                pix <= pix + 1'b1;
            end
            if (adv) begin
                sw_tmr <= '0;
                sw_cnt <= '0;
            end else if (sweeping) begin
                if (sw_tmr >= sw_period - 1'b1) begin
                    sw_tmr <= '0;
                    sw_cnt <= sw_cnt + 1'b1;
                end else begin
                    sw_tmr <= sw_tmr + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ccd_vseq_pattern.sv
module ccd_vseq_pattern
    import ccd_vseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seq_e             mode,
    input  logic [PIX_W-1:0] pix,
    input  logic             sweep_hi,
    input  glob_t            glob,
    output logic [NV-1:0]    v_o,
    output logic             sg_o,
    output logic             hblk_o,
    output logic             clamp_o
);
    logic [NV-1:0] raw_v;
    logic          raw_sg, raw_hb, raw_cl;

    always_comb begin
        raw_v  = '0;
        raw_sg = 1'b0;
        raw_hb = in_win(pix, glob.hblk);
        raw_cl = in_win(pix, glob.clamp);
        unique case (mode)
            SEQ_SWEEP: begin
                raw_v  = {NV{sweep_hi}};
                raw_hb = 1'b1;
            end
            SEQ_SHIFT: begin
                for (int k = 0; k < NV; k++) raw_v[k] = in_win(pix, glob.grp_a[k]);
            end
            SEQ_GATE: begin
                for (int k = 0; k < NV; k++) raw_v[k] = in_win(pix, glob.grp_b[k]);
                raw_sg = in_win(pix, glob.gate);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) {clamp_o, hblk_o, sg_o, v_o} <= '0;
        else     {clamp_o, hblk_o, sg_o, v_o} <= {raw_cl, raw_hb, raw_sg, raw_v} ^ glob.pol;
    end
endmodule

// File: rtl/ccd_vseq.sv
module ccd_vseq
    import ccd_vseq_pkg::*;
#(
    parameter int NFIELDS = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hsync,
    input  logic        vsync,
    input  logic        wr_en,
    input  logic [5:0]  wr_addr,
    input  logic [15:0] wr_data,
    output logic [5:0]  v_out,
    output logic        sg_out,
    output logic        hblk_out,
    output logic        clamp_out
);
    localparam int FLD_W = (NFIELDS > 1) ? $clog2(NFIELDS) : 1;

    fld_t             cur_fld;
    glob_t            act_glob;
    logic [PIX_W-1:0] pix;
    logic [FLD_W-1:0] field_q;
    logic [REG_W-1:0] region_q;
    seq_e             mode;
    logic             sweep_hi;

    ccd_vseq_regs #(.NFIELDS(NFIELDS)) u_regs (
        .clk(clk), .rst(rst), .vsync(vsync),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .field(field_q), .cur_fld(cur_fld), .act_glob(act_glob)
    );

    ccd_vseq_timebase #(.NFIELDS(NFIELDS)) u_tb (
        .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
        .cur_fld(cur_fld), .sw_period(act_glob.sw_period), .sw_count(act_glob.sw_count),
        .pix(pix), .field(field_q), .region(region_q), .mode(mode), .sweep_hi(sweep_hi)
    );

    ccd_vseq_pattern u_pat (
        .clk(clk), .rst(rst), .mode(mode), .pix(pix), .sweep_hi(sweep_hi),
        .glob(act_glob), .v_o(v_out), .sg_o(sg_out), .hblk_o(hblk_out), .clamp_o(clamp_out)
    );
endmodule

// File: rtl/ccd_vseq_chk.sv
module ccd_vseq_chk
    import ccd_vseq_pkg::*;
#(
    parameter int  NFIELDS = 3,
    localparam int FLD_W   = (NFIELDS > 1) ? $clog2(NFIELDS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             hsync,
    input logic             vsync,
    input logic [FLD_W-1:0] field,
    input logic [REG_W-1:0] region,
    input seq_e             mode,
    input glob_t            act_glob,
    input logic [NV-1:0]    v_out,
    input logic             sg_out,
    input logic             hblk_out,
    input logic             clamp_out
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (v_out == '0 && !sg_out && !hblk_out && !clamp_out));

    assert_shadow_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !vsync |=> $stable(act_glob));

    assert_field_step_R3: assert property (@(posedge clk) disable iff (rst)
        vsync |=> field == (($past(field) == FLD_W'(NFIELDS - 1)) ? '0 : $past(field) + 1'b1));

    assert_region_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!hsync && !vsync) |=> $stable(region));

    assert_region_step_R4: assert property (@(posedge clk) disable iff (rst)
        (hsync && !vsync) |=> (region == $past(region) || region == $past(region) + 1'b1));

    assert_region_last_R4: assert property (@(posedge clk) disable iff (rst)
        (!vsync && region == REG_W'(NR - 1)) |=> region == REG_W'(NR - 1));

    assert_gate_mode_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) != SEQ_GATE) |-> sg_out == $past(act_glob.pol[NV]));

    assert_sweep_blank_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == SEQ_SWEEP) |-> hblk_out == !$past(act_glob.pol[NV+1]));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == SEQ_IDLE) |-> v_out == $past(act_glob.pol[NV-1:0]));
endmodule

bind ccd_vseq ccd_vseq_chk #(.NFIELDS(NFIELDS)) u_chk (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
    .field(field_q), .region(region_q), .mode(mode), .act_glob(act_glob),
    .v_out(v_out), .sg_out(sg_out), .hblk_out(hblk_out), .clamp_out(clamp_out)
);

// File: tb/ccd_vseq_bench.sv
module ccd_vseq_bench;
    localparam int M_IDLE = 0, M_SWEEP = 1, M_SHIFT = 2, M_GATE = 3;
    localparam int NS = 14;
    localparam int SMP [NS] = '{0, 3, 4, 5, 9, 12, 15, 16, 20, 22, 25, 29, 31, 35};

    logic clk = 1'b0, rst = 1'b1, hsync = 1'b0, vsync = 1'b0, wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  v_out;
    logic        sg_out, hblk_out, clamp_out;

    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;
    logic [8:0] pol_now = '0, pol_pend = '0;

    ccd_vseq u_ccd_vseq (
        .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .v_out(v_out), .sg_out(sg_out), .hblk_out(hblk_out), .clamp_out(clamp_out)
    );

    always #5 clk = ~clk;

    function automatic int a_on(int k);  return 4 + 2 * k;  endfunction
    function automatic int a_off(int k); return 10 + 2 * k; endfunction
    function automatic int b_on(int k);  return 20 + k;     endfunction
    function automatic int b_off(int k); return 24 + k;     endfunction

    function automatic logic [8:0] expect_out(int mode, int p);
        logic [5:0] v = '0;
        logic sg = 1'b0;
        logic hb = (p >= 0) && (p < 3);
        logic cl = (p >= 30) && (p < 34);
        for (int k = 0; k < 6; k++) begin
            if (mode == M_SHIFT) v[k] = (p >= a_on(k)) && (p < a_off(k));
            if (mode == M_GATE)  v[k] = (p >= b_on(k)) && (p < b_off(k));
        end
        if (mode == M_GATE) sg = (p >= 12) && (p < 16);
        return {cl, hb, sg, v} ^ pol_now;
    endfunction

    task automatic report();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(addr); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_vsync();
        @(negedge clk); vsync = 1'b1;
        @(negedge clk); vsync = 1'b0;
        pol_now = pol_pend;
    endtask

    // starts a line, samples every listed pixel position
    task automatic check_line(int mode, string req);
        int done = 0;
        @(negedge clk); hsync = 1'b1;
        @(negedge clk); hsync = 1'b0;
        for (int i = 0; i < NS; i++) begin
            repeat (SMP[i] + 1 - done) @(negedge clk);
            done = SMP[i] + 1;
            check(req, {clamp_out, hblk_out, sg_out, v_out}, expect_out(mode, SMP[i]));
        end
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 reset outputs", {clamp_out, hblk_out, sg_out, v_out}, 9'h000);
        end
    endtask

    task automatic t_program_shadow();
        for (int k = 0; k < 6; k++) begin
            wr(32 + k, (a_off(k) << 8) | a_on(k));
            wr(40 + k, (b_off(k) << 8) | b_on(k));
        end
        wr(48, (16 << 8) | 12);
        wr(49, (3 << 8) | 0);
        wr(50, (34 << 8) | 30);
        wr(4, M_SHIFT);
        wr(12, M_GATE);
        wr(20, M_IDLE);
        // not yet committed: blanking window would be active at pixel 1
        @(negedge clk); hsync = 1'b1;
        @(negedge clk); hsync = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 no effect before vsync", {clamp_out, hblk_out, sg_out, v_out}, 9'h000);
    endtask

    task automatic t_field_rotation();
        pulse_vsync();
        check_line(M_SHIFT, "R1 R3 R5 R6 R9 first field is 0");
        pulse_vsync();
        check_line(M_GATE, "R3 R5 R7 field 1");
        pulse_vsync();
        check_line(M_IDLE, "R3 R5 R10 field 2");
        pulse_vsync();
        check_line(M_SHIFT, "R3 field wrap to 0");
    endtask

    task automatic t_regions();
        wr(1, 2); wr(2, 4); wr(3, 5);
        wr(4, M_IDLE); wr(5, M_SHIFT); wr(6, M_GATE); wr(7, M_SHIFT);
        wr(9, 1); wr(12, M_SWEEP); wr(13, M_SHIFT);
        wr(51, (3 << 8) | 4);
        pulse_vsync();
        pulse_vsync();
        pulse_vsync();
        check_line(M_IDLE,  "R4 line1 region0");
        check_line(M_SHIFT, "R4 R12 line2 region1");
        check_line(M_SHIFT, "R4 line3 region1");
        check_line(M_GATE,  "R4 R7 line4 region2");
        check_line(M_SHIFT, "R4 R12 line5 region3 shares pattern");
        check_line(M_SHIFT, "R4 line6 holds last region");
    endtask

    task automatic t_sweep();
        pulse_vsync();
        for (int k = 0; k < 16; k++) begin
            logic hi;
            @(negedge clk);
            hi = (k < 12) && ((k % 4) < 2);
            check("R8 sweep pulse train", {clamp_out, hblk_out, sg_out, v_out},
                  {1'b0, 1'b1, 1'b0, {6{hi}}} ^ pol_now);
        end
        check_line(M_SHIFT, "R4 R8 boundary ends sweep");
    endtask

    task automatic t_polarity();
        pol_pend = 9'h156;
        wr(52, 9'h156);
        check_line(M_SHIFT, "R2 R11 polarity waits for vsync");
        pulse_vsync();
        check_line(M_IDLE, "R10 R11 idle with polarity");
        pulse_vsync();
        check_line(M_IDLE, "R11 region0 with polarity");
        check_line(M_SHIFT, "R6 R11 shift with polarity");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        t_reset();
        t_program_shadow();
        t_field_rotation();
        t_regions();
        t_sweep();
        t_polarity();
        repeat (4) @(negedge clk);
        report();
    end
endmodule